// File: doc/BRIEF.md
# Stash Address Window Matcher

This block sits beside a shared cache and screens external writes, such as snoop writes from an I/O agent. It decides whether each write lands inside one of a small set of programmed address windows. When it does, the cache line is allocated and locked ("stashed") so that a processor can later read the data without a miss. The cache arrays, tag lookup, replacement and the bus protocol all sit outside this block.

Each window has three registers, written through a simple write port: the low part of the base, the high part of the base, and a control word. The control word holds an enable bit and a size. Addresses are line addresses, 28 bits wide. A window takes part in matching only when all three of its registers have been written since reset and its enable bit is set.

For each valid request the block compares the address against every active window. One clock later it reports a hit flag, the index of the winning window and a lock request, all qualified by a valid output.

Top module: `stash_win_match`

## Requirements
- R1: After a synchronous reset, out_valid, out_hit, out_lock and out_win are 0, every window register is zero and every window is inactive, so a request misses.
- R2: A window is inactive until its base-low, base-high and control registers have each been written at least once since reset. Writing only some of them leaves every request to that window a miss.
- R3: Register write map: reg_sel 0 loads base bits [23:0] from reg_wdata[23:0]. reg_sel 1 loads base bits [27:24] from reg_wdata[3:0]. reg_sel 2 loads the control word: enable in reg_wdata[0] and size in reg_wdata[5:1]. reg_sel 3 writes nothing. reg_win selects the window.
- R4: The size is log2 of the window length in lines. Only address bits at or above the size take part in the compare. Base bits below the size are ignored, so a misaligned base acts like its aligned value.
- R5: A size above 28 is treated as 28, and such a window matches every address.
- R6: When several active windows match, the lowest-numbered one is reported.
- R7: out_valid is high exactly one clock after req_valid is high. out_hit and out_lock are 0 whenever out_valid is 0, and out_win is 0 on a miss.
- R8: out_lock equals out_hit whenever out_valid is high.
- R9: A window whose control enable bit is 0 never matches, even when all three of its registers have been written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_win | input | 2 | Window selected for the register write |
| reg_sel | input | 2 | Register selected within the window |
| reg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | External write request valid |
| req_addr | input | 28 | Line address of the external write |
| out_valid | output | 1 | Result valid, one clock after req_valid |
| out_hit | output | 1 | Address fell in an active window |
| out_win | output | 2 | Index of the winning window |
| out_lock | output | 1 | Request to allocate and lock the line |

## Verification
The addresses are chosen to sit on both sides of every window edge: first and last line inside, and the first line past the end. An off-by-one error in the size mask therefore shows as a miss or a false hit. Two windows overlap, which separates correct lowest-index priority from a highest-index or any-match encoder. One window is given a deliberately misaligned base, which separates masked comparison from a full-width compare. Partial register programming, a cleared enable bit and an oversize size field each flip a known hit into a miss, or a miss into a hit, which exposes a missing written flag, an ignored enable or a missing clamp.

// File: rtl/stash_win_pkg.sv
package stash_win_pkg;
    localparam int ADDR_W    = 28;
    localparam int LO_W      = 24;
    localparam int HI_W      = ADDR_W - LO_W;
    localparam int SIZE_W    = 5;
    localparam int DATA_W    = 32;
    localparam int NUM_WIN   = 4;
    localparam int WIN_IDX_W = $clog2(NUM_WIN);
    localparam int NUM_REGS  = 3;

    typedef enum logic [1:0] {
        SEL_BASE_LO = 2'd0,
        SEL_BASE_HI = 2'd1,
        SEL_CTRL    = 2'd2,
        SEL_NONE    = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [ADDR_W-1:0]   base;
        logic                en;
        logic [SIZE_W-1:0]   size;
        logic [NUM_REGS-1:0] written;
    } win_cfg_t;

    // Clamp the size field to the address width.
    function automatic logic [SIZE_W-1:0] clamp_size(input logic [SIZE_W-1:0] sz);
        return (sz > SIZE_W'(ADDR_W)) ? SIZE_W'(ADDR_W) : sz;
    endfunction

    // Bits at or above the effective size take part in the compare.
    function automatic logic [ADDR_W-1:0] size_mask(input logic [SIZE_W-1:0] sz);
        logic [SIZE_W-1:0] eff;
        logic [ADDR_W-1:0] m;
        eff = clamp_size(sz);
        for (int i = 0; i < ADDR_W; i++) begin
            m[i] = (i >= int'(eff));
        end
        return m;
    endfunction
endpackage

// File: rtl/stash_win_regs.sv
module stash_win_regs
    import stash_win_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  reg_sel_e          wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output win_cfg_t          cfg,
    output logic              active
);
    win_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            unique case (wr_sel)
                SEL_BASE_LO: begin
                    cfg_q.base[LO_W-1:0] <= wr_data[LO_W-1:0];
                    cfg_q.written[0]     <= 1'b1;
                end
                SEL_BASE_HI: begin
                    cfg_q.base[ADDR_W-1:LO_W] <= wr_data[HI_W-1:0];
                    cfg_q.written[1]          <= 1'b1;
                end
                SEL_CTRL: begin
                    cfg_q.en         <= wr_data[0];
                    cfg_q.size       <= wr_data[SIZE_W:1];
                    cfg_q.written[2] <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign cfg    = cfg_q;
    assign active = cfg_q.en && (&cfg_q.written);

    // R2: a window can only turn active through a register write
    assert_active_after_write_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |-> $past(wr_en));
endmodule

// File: rtl/stash_win_cmp.sv
module stash_win_cmp
    import stash_win_pkg::*;
(
    input  win_cfg_t          cfg,
    input  logic              active,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    logic [ADDR_W-1:0] mask;

    always_comb begin
        mask = size_mask(cfg.size);
        hit  = active && (((addr ^ cfg.base) & mask) == '0);
    end
endmodule

// File: rtl/stash_win_match.sv
module stash_win_match
    import stash_win_pkg::*;
#(
    parameter int N_WIN = NUM_WIN,
    localparam int IDX_W = (N_WIN > 1) ? $clog2(N_WIN) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [IDX_W-1:0]  reg_win,
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              out_valid,
    output logic              out_hit,
    output logic [IDX_W-1:0]  out_win,
    output logic              out_lock
);
    logic [N_WIN-1:0] match_vec;
    logic             any_hit;
    logic [IDX_W-1:0] first_idx;

    for (genvar g = 0; g < N_WIN; g++) begin : g_win
        win_cfg_t cfg;
        logic     active;
        logic     wr_en;

        assign wr_en = reg_we && (reg_win == IDX_W'(g));

        stash_win_regs u_regs (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (wr_en),
            .wr_sel  (reg_sel_e'(reg_sel)),
            .wr_data (reg_wdata),
            .cfg     (cfg),
            .active  (active)
        );

        stash_win_cmp u_cmp (
            .cfg    (cfg),
            .active (active),
            .addr   (req_addr),
            .hit    (match_vec[g])
        );
    end

    // Lowest index wins: scan downward so the last assignment is the lowest.
    always_comb begin
        any_hit   = |match_vec;
        first_idx = '0;
        for (int i = N_WIN - 1; i >= 0; i--) begin
            if (match_vec[i]) first_idx = IDX_W'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_hit   <= 1'b0;
            out_win   <= '0;
            out_lock  <= 1'b0;
        end else begin
            out_valid <= req_valid;
            out_hit   <= req_valid && any_hit;
            out_win   <= (req_valid && any_hit) ? first_idx : '0;
            out_lock  <= req_valid && any_hit;
        end
    end

    assert_valid_delay_R7: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> out_valid);
    assert_no_spurious_valid_R7: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !out_valid);
    assert_hit_qualified_R7: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (!out_hit && !out_lock));
    assert_lock_follows_hit_R8: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_lock == out_hit));
    assert_lowest_wins_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && match_vec[0]) |=> (out_hit && out_win == '0));
endmodule

// File: tb/test_stash_win_match.sv
module test_stash_win_match;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;
    localparam int N_VEC      = 12;
    // Entry: [31] expected hit, [29:28] expected window, [27:0] address
    localparam logic [31:0] VEC [N_VEC] = '{
        32'h81234567, 32'h8123456F, 32'hA1234570, 32'hA12345FF,
        32'h01234600, 32'h98000000, 32'h98FFFFFF, 32'h09000000,
        32'hB0000AB0, 32'hB0000ABF, 32'h00000AC0, 32'h07FFFFFF
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_we;
    logic [1:0]  reg_win;
    logic [1:0]  reg_sel;
    logic [31:0] reg_wdata;
    logic        req_valid;
    logic [27:0] req_addr;
    logic        out_valid;
    logic        out_hit;
    logic [1:0]  out_win;
    logic        out_lock;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stash_win_match i_stash_win_match (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_win   (reg_win),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .out_valid (out_valid),
        .out_hit   (out_hit),
        .out_win   (out_win),
        .out_lock  (out_lock)
    );

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d cycles, expected below %0d", cycles, WATCHDOG);
            report();
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] win, input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        reg_we = 1'b1; reg_win = win; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    // Issue one request, then check the registered result one clock later.
    task automatic req(input string tag, input logic [27:0] addr,
                       input logic hit, input logic [1:0] win);
        @(negedge clk);
        req_valid = 1'b1; req_addr = addr;
        @(negedge clk);
        req_valid = 1'b0;
        chk(tag, {27'd0, out_valid, out_hit, out_win, out_lock},
                 {27'd0, 1'b1, hit, hit ? win : 2'd0, hit});
    endtask

    function automatic logic [31:0] ctrl(input logic en, input logic [4:0] sz);
        return {26'd0, sz, en};
    endfunction

    initial begin
        rst = 1'b1; reg_we = 1'b0; reg_win = '0; reg_sel = '0; reg_wdata = '0;
        req_valid = 1'b0; req_addr = '0;
        repeat (3) @(negedge clk);
        // R1: reset state of the outputs
        chk("R1 reset outputs", {28'd0, out_valid, out_hit, out_win, out_lock}, 32'd0);
        rst = 1'b0;
        // R1: no window active after reset
        req("R1 miss after reset", 28'h0000000, 1'b0, 2'd0);
        // R7: valid drops one clock after the request stops
        @(negedge clk);
        chk("R7 valid drops", {30'd0, out_valid, out_hit}, 32'd0);

        // R3: program windows through the register map
        wr(2'd0, 2'd0, 32'h00234560); wr(2'd0, 2'd1, 32'h1); wr(2'd0, 2'd2, ctrl(1'b1, 5'd4));
        wr(2'd1, 2'd0, 32'h0);        wr(2'd1, 2'd1, 32'h8); wr(2'd1, 2'd2, ctrl(1'b1, 5'd24));
        wr(2'd2, 2'd0, 32'h00234500); wr(2'd2, 2'd1, 32'h1); wr(2'd2, 2'd2, ctrl(1'b1, 5'd8));
        // R2: window 3 with base-high not yet written stays inactive
        wr(2'd3, 2'd0, 32'h00000ABC); wr(2'd3, 2'd2, ctrl(1'b1, 5'd4));
        req("R2 partial config misses", 28'h0000AB5, 1'b0, 2'd0);
        // R3: reg_sel 3 writes nothing, window 3 still inactive
        wr(2'd3, 2'd3, 32'hFFFFFFFF);
        req("R3 unused select ignored", 28'h0000AB5, 1'b0, 2'd0);
        wr(2'd3, 2'd1, 32'h0);
        req("R2 full config hits", 28'h0000AB5, 1'b1, 2'd3);

        // Table walk: R4 edges and misaligned base, R6 overlap, R8 lock
        for (int k = 0; k < N_VEC; k++) begin
            req($sformatf("R4/R6/R8 vector %0d", k), VEC[k][27:0], VEC[k][31], VEC[k][29:28]);
        end

        // R9: disabled window never matches
        wr(2'd1, 2'd2, ctrl(1'b0, 5'd24));
        req("R9 disabled window", 28'h8000000, 1'b0, 2'd0);
        // R5: oversize size matches everything
        wr(2'd1, 2'd2, ctrl(1'b1, 5'd31));
        req("R5 clamp matches all", 28'h7FFFFFF, 1'b1, 2'd1);
        // R6: window 0 still wins over the match-all window 1
        req("R6 lower index wins", 28'h1234567, 1'b1, 2'd0);

        // R1/R2: reset clears written flags; a control write alone is not enough
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        wr(2'd0, 2'd2, ctrl(1'b1, 5'd28));
        req("R2 after reset ctrl only", 28'h1234567, 1'b0, 2'd0);

        report();
    end
endmodule